// File: doc/BRIEF.md
# SD Video Master Sync Generator

This block is the timing master for a standard-definition interlaced video output. It counts pixel positions and line numbers and from them drives active-low horizontal sync, vertical sync and blanking strobes, together with a field flag and a sample-phase code for the active picture. Two line standards are built in: a 625-line standard (`pal_sel` = 1) and a 525-line standard (`pal_sel` = 0). Each standard has its own line length, sync width, active-window start and vertical blanking depth.

The input clock runs at twice the pixel rate. An internal divide-by-two enable, brought out as `pix_tick`, advances the pixel counter on every second clock. Every output therefore holds for exactly two clocks per pixel. Field parity shows in where vertical sync falls within a line. In the first field it falls on the same pixel as horizontal sync, at the start of line 1. In the second field it falls in the middle of line `(LINES+1)/2`, while horizontal sync is high.

All outputs are plain level and strobe signals with no handshake. A downstream pixel source follows `act_valid` and `act_phase`, and cannot stall the timing: there is no back-pressure. The standard select is captured only when a new frame starts, or while reset is held.

Top module: `sdsync_gen`

## Requirements
- R1: `pix_tick` is 0 while reset is held and toggles on every clock afterwards, starting at 1 in the first clock after release. The pixel position advances only on clocks where `pix_tick` is 1, so each pixel lasts two clocks.
- R2: A line spans LINE pixels, which is 864 or 858 by default. Consecutive falling edges of `hsync_n` are 2·LINE clocks apart, and pixel LINE-1 is the last pixel of each line.
- R3: `hsync_n` is 0 for pixels 0 to HS-1 of every line (12 or 16 by default) and 1 elsewhere.
- R4: First field: `vsync_n` falls at line 1 pixel 0, together with `hsync_n`. It stays 0 through the end of line VS (default 3). `field_even` is 0 from line 1 until the even-field start.
- R5: Even field: with MID = (LINES+1)/2 and HALF = LINE/2, `vsync_n` falls at line MID pixel HALF while `hsync_n` is 1. It stays 0 until pixel HALF-1 of line MID+VS. `field_even` is 1 from line MID pixel HALF to the end of the frame.
- R6: `blank_n` is 0 on pixels below ACT (132 or 122 by default), on pixels at or beyond ACT+ACTW (default width 720), on lines 1 to VBI, and on lines MID to MID+VBI-1 (VBI is 25 or 20 by default).
- R7: `act_valid` equals `blank_n`. While `act_valid` is 1, `act_phase` = (pixel − ACT) mod 4, coded 0 = Cb, 1 = Y, 2 = Cr, 3 = Y. While `act_valid` is 0, `act_phase` is 0.
- R8: While reset is held, the position is line 1 pixel 0 of the first field: `hsync_n`, `vsync_n`, `blank_n`, `field_even`, `act_valid` and `act_phase` are all 0.
- R9: The standard is loaded from `pal_sel` during reset and again only at the wrap from the last pixel of the last line to line 1. A change of `pal_sel` in mid-frame has no effect until that wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rst | input | 1 | Synchronous reset, active high |
| pal_sel | input | 1 | 1 = 625-line standard, 0 = 525-line standard |
| pix_tick | output | 1 | Pixel-rate enable, high on every other clock |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank_n | output | 1 | Blanking, active low |
| field_even | output | 1 | 1 during the second (even) field |
| act_valid | output | 1 | High on active picture samples |
| act_phase | output | 2 | Sample kind: 0 Cb, 1 Y, 2 Cr, 3 Y |

## Verification
Some properties hold on every cycle, and the assertions check these continuously. The enable toggles. Outputs stay stable between ticks. Sync never appears inside the picture. The phase steps by one per active pixel and rests at 0 outside the picture. Each vertical sync edge carries the parity that matches `field_even`. The standard changes only at a frame start. Other behaviour is tied to particular positions in the frame, and only the bench's scenarios can show it. This covers the exact sync widths, the active-window edges, the vertical-blank lines, where the mid-line vertical sync sits, and the deferred switch between the two standards. The bench uses shrunken line and frame parameters so that several whole frames fit in a short run.

// File: rtl/sdsync_pkg.sv
package sdsync_pkg;

  typedef enum logic {
    MODE_525 = 1'b0,
    MODE_625 = 1'b1
  } vmode_e;

  typedef enum logic [1:0] {
    PH_CB = 2'd0,
    PH_YA = 2'd1,
    PH_CR = 2'd2,
    PH_YB = 2'd3
  } phase_e;

  typedef struct packed {
    logic   hsync_n;
    logic   vsync_n;
    logic   blank_n;
    logic   field_even;
    logic   act_valid;
    phase_e phase;
  } sync_out_t;

endpackage

// File: rtl/sdsync_tick.sv
module sdsync_tick (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  logic tick_q;

  always_ff @(posedge clk) begin
    if (rst) tick_q <= 1'b0;
    else     tick_q <= ~tick_q;
  end

  assign tick = tick_q;
endmodule

// File: rtl/sdsync_timing.sv
module sdsync_timing
  import sdsync_pkg::*;
#(
  parameter int PAL_LINE   = 864,
  parameter int NTSC_LINE  = 858,
  parameter int PAL_LINES  = 625,
  parameter int NTSC_LINES = 525,
  parameter int PX_W       = 10,
  parameter int LN_W       = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            pal_sel,
  output vmode_e          mode,
  output logic [PX_W-1:0] px,
  output logic [LN_W-1:0] line
);
  vmode_e          mode_q;
  logic [PX_W-1:0] px_q;
  logic [LN_W-1:0] line_q;
  logic [PX_W-1:0] last_px;
  logic [LN_W-1:0] last_line;

  always_comb begin
    if (mode_q == MODE_625) begin
      last_px   = PX_W'(PAL_LINE - 1);
      last_line = LN_W'(PAL_LINES);
    end else begin
      last_px   = PX_W'(NTSC_LINE - 1);
      last_line = LN_W'(NTSC_LINES);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      px_q   <= '0;
      line_q <= LN_W'(1);
      mode_q <= vmode_e'(pal_sel);
    end else if (tick) begin
      if (px_q == last_px) begin
        px_q <= '0;
        if (line_q == last_line) begin
          line_q <= LN_W'(1);
          mode_q <= vmode_e'(pal_sel);
        end else begin
          line_q <= line_q + LN_W'(1);
        end
      end else begin
        px_q <= px_q + PX_W'(1);
      end
    end
  end

  assign mode = mode_q;
  assign px   = px_q;
  assign line = line_q;
endmodule

// File: rtl/sdsync_decode.sv
module sdsync_decode
  import sdsync_pkg::*;
#(
  parameter int PAL_LINE   = 864,
  parameter int NTSC_LINE  = 858,
  parameter int PAL_LINES  = 625,
  parameter int NTSC_LINES = 525,
  parameter int PAL_HS     = 12,
  parameter int NTSC_HS    = 16,
  parameter int PAL_ACT    = 132,
  parameter int NTSC_ACT   = 122,
  parameter int ACT_W      = 720,
  parameter int PAL_VBI    = 25,
  parameter int NTSC_VBI   = 20,
  parameter int VS_LINES   = 3,
  parameter int PX_W       = 10,
  parameter int LN_W       = 10
) (
  input  vmode_e          mode,
  input  logic [PX_W-1:0] px,
  input  logic [LN_W-1:0] line,
  output sync_out_t       o
);
  localparam int PAL_MID  = (PAL_LINES + 1) / 2;
  localparam int NTSC_MID = (NTSC_LINES + 1) / 2;

  logic [PX_W-1:0] hs_len, act_s, act_e, half;
  logic [LN_W-1:0] vbi, mid, mid_vs, mid_vbi;
  logic            odd_vs, even_vs, second, vblank, in_act, valid;
  logic [1:0]      ph;

  always_comb begin
    if (mode == MODE_625) begin
      hs_len  = PX_W'(PAL_HS);
      act_s   = PX_W'(PAL_ACT);
      act_e   = PX_W'(PAL_ACT + ACT_W);
      half    = PX_W'(PAL_LINE / 2);
      vbi     = LN_W'(PAL_VBI);
      mid     = LN_W'(PAL_MID);
      mid_vs  = LN_W'(PAL_MID + VS_LINES);
      mid_vbi = LN_W'(PAL_MID + PAL_VBI);
    end else begin
      hs_len  = PX_W'(NTSC_HS);
      act_s   = PX_W'(NTSC_ACT);
      act_e   = PX_W'(NTSC_ACT + ACT_W);
      half    = PX_W'(NTSC_LINE / 2);
      vbi     = LN_W'(NTSC_VBI);
      mid     = LN_W'(NTSC_MID);
      mid_vs  = LN_W'(NTSC_MID + VS_LINES);
      mid_vbi = LN_W'(NTSC_MID + NTSC_VBI);
    end
  end

  always_comb begin
    odd_vs  = (line <= LN_W'(VS_LINES));
    even_vs = ((line == mid) && (px >= half)) ||
              ((line > mid) && (line < mid_vs)) ||
              ((line == mid_vs) && (px < half));
    second  = (line > mid) || ((line == mid) && (px >= half));
    vblank  = (line <= vbi) || ((line >= mid) && (line < mid_vbi));
    in_act  = (px >= act_s) && (px < act_e);
    valid   = in_act && !vblank;
    ph      = px[1:0] - act_s[1:0];

    o.hsync_n    = !(px < hs_len);
    o.vsync_n    = !(odd_vs || even_vs);
    o.blank_n    = valid;
    o.field_even = second;
    o.act_valid  = valid;
    o.phase      = valid ? phase_e'(ph) : PH_CB;
  end
endmodule

// File: rtl/sdsync_gen.sv
module sdsync_gen
  import sdsync_pkg::*;
#(
  parameter int PAL_LINE   = 864,
  parameter int NTSC_LINE  = 858,
  parameter int PAL_LINES  = 625,
  parameter int NTSC_LINES = 525,
  parameter int PAL_HS     = 12,
  parameter int NTSC_HS    = 16,
  parameter int PAL_ACT    = 132,
  parameter int NTSC_ACT   = 122,
  parameter int ACT_W      = 720,
  parameter int PAL_VBI    = 25,
  parameter int NTSC_VBI   = 20,
  parameter int VS_LINES   = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pal_sel,
  output logic       pix_tick,
  output logic       hsync_n,
  output logic       vsync_n,
  output logic       blank_n,
  output logic       field_even,
  output logic       act_valid,
  output logic [1:0] act_phase
);
  localparam int MAX_LINE  = (PAL_LINE > NTSC_LINE) ? PAL_LINE : NTSC_LINE;
  localparam int MAX_LINES = (PAL_LINES > NTSC_LINES) ? PAL_LINES : NTSC_LINES;
  localparam int PX_W      = $clog2(MAX_LINE + 1);
  localparam int LN_W      = $clog2(MAX_LINES + VS_LINES + PAL_VBI + NTSC_VBI + 1);

  logic            tick;
  vmode_e          mode_q;
  logic [PX_W-1:0] px;
  logic [LN_W-1:0] line;
  sync_out_t       dec;

  sdsync_tick u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  sdsync_timing #(
    .PAL_LINE   (PAL_LINE),
    .NTSC_LINE  (NTSC_LINE),
    .PAL_LINES  (PAL_LINES),
    .NTSC_LINES (NTSC_LINES),
    .PX_W       (PX_W),
    .LN_W       (LN_W)
  ) u_timing (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .pal_sel (pal_sel),
    .mode    (mode_q),
    .px      (px),
    .line    (line)
  );

  sdsync_decode #(
    .PAL_LINE   (PAL_LINE),
    .NTSC_LINE  (NTSC_LINE),
    .PAL_LINES  (PAL_LINES),
    .NTSC_LINES (NTSC_LINES),
    .PAL_HS     (PAL_HS),
    .NTSC_HS    (NTSC_HS),
    .PAL_ACT    (PAL_ACT),
    .NTSC_ACT   (NTSC_ACT),
    .ACT_W      (ACT_W),
    .PAL_VBI    (PAL_VBI),
    .NTSC_VBI   (NTSC_VBI),
    .VS_LINES   (VS_LINES),
    .PX_W       (PX_W),
    .LN_W       (LN_W)
  ) u_decode (
    .mode (mode_q),
    .px   (px),
    .line (line),
    .o    (dec)
  );

  assign pix_tick   = tick;
  assign hsync_n    = dec.hsync_n;
  assign vsync_n    = dec.vsync_n;
  assign blank_n    = dec.blank_n;
  assign field_even = dec.field_even;
  assign act_valid  = dec.act_valid;
  assign act_phase  = dec.phase;
endmodule

// File: rtl/sdsync_chk.sv
module sdsync_chk (
  input logic       clk,
  input logic       rst,
  input logic       pix_tick,
  input logic       hsync_n,
  input logic       vsync_n,
  input logic       blank_n,
  input logic       field_even,
  input logic       act_valid,
  input logic [1:0] act_phase,
  input logic       mode_bit
);
  // R1: enable alternates
  p_tick_toggle_r1: assert property (@(posedge clk) disable iff (rst)
    pix_tick |=> !pix_tick);
  p_tick_resume_r1: assert property (@(posedge clk) disable iff (rst)
    !pix_tick |=> pix_tick);

  // R1: nothing moves between pixel ticks
  p_hold_between_r1: assert property (@(posedge clk) disable iff (rst)
    !pix_tick |=> ($stable(hsync_n) && $stable(vsync_n) && $stable(blank_n)
                   && $stable(field_even) && $stable(act_phase)));

  // R6: sync pulse always falls inside blanking
  p_hs_blanked_r6: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> !blank_n);

  // R7: phase rests at Cb outside picture
  p_phase_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !act_valid |-> (act_phase == 2'd0));

  // R7: phase steps once per active pixel
  p_phase_step_r7: assert property (@(posedge clk) disable iff (rst)
    (act_valid && pix_tick) |=> (!act_valid || act_phase == $past(act_phase) + 2'd1));

  // R4 and R5: parity of the vertical sync edge matches the field flag
  p_vs_parity_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(vsync_n) |-> (field_even ? hsync_n : $fell(hsync_n)));

  // R9: standard changes only at line 1 pixel 0 of the first field
  p_mode_frame_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_bit) |-> (!hsync_n && !vsync_n && !field_even));
endmodule

bind sdsync_gen sdsync_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .pix_tick   (pix_tick),
  .hsync_n    (hsync_n),
  .vsync_n    (vsync_n),
  .blank_n    (blank_n),
  .field_even (field_even),
  .act_valid  (act_valid),
  .act_phase  (act_phase),
  .mode_bit   (mode_q)
);

// File: tb/tb_sdsync_gen.sv
module tb_sdsync_gen;
  localparam int CLK_PERIOD = 10;

  // shrunken standards
  localparam int P_LINE = 40, N_LINE = 36;
  localparam int P_LINES = 11, N_LINES = 9;
  localparam int P_HS = 4, N_HS = 6;
  localparam int P_ACT = 10, N_ACT = 8;
  localparam int ACTW = 24, P_VBI = 2, N_VBI = 2, VSL = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pal_sel = 1'b1;
  logic pix_tick, hsync_n, vsync_n, blank_n, field_even, act_valid;
  logic [1:0] act_phase;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdsync_gen #(
    .PAL_LINE(P_LINE), .NTSC_LINE(N_LINE), .PAL_LINES(P_LINES), .NTSC_LINES(N_LINES),
    .PAL_HS(P_HS), .NTSC_HS(N_HS), .PAL_ACT(P_ACT), .NTSC_ACT(N_ACT), .ACT_W(ACTW),
    .PAL_VBI(P_VBI), .NTSC_VBI(N_VBI), .VS_LINES(VSL)
  ) dut (
    .clk(clk), .rst(rst), .pal_sel(pal_sel), .pix_tick(pix_tick),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .blank_n(blank_n),
    .field_even(field_even), .act_valid(act_valid), .act_phase(act_phase)
  );

  // independent position model (R1, R2, R9)
  logic bt;
  int bpx, bline;
  logic bpal;
  always @(posedge clk) begin
    if (rst) begin
      bt <= 1'b0; bpx <= 0; bline <= 1; bpal <= pal_sel;
    end else begin
      bt <= ~bt;
      if (bt) begin
        if (bpx == (bpal ? P_LINE : N_LINE) - 1) begin
          bpx <= 0;
          if (bline == (bpal ? P_LINES : N_LINES)) begin
            bline <= 1; bpal <= pal_sel;
          end else bline <= bline + 1;
        end else bpx <= bpx + 1;
      end
    end
  end

  typedef struct packed {
    logic       sel;
    logic [7:0] line;
    logic [7:0] px;
    logic [6:0] exp;   // {hsync_n, vsync_n, blank_n, field_even, act_valid, act_phase}
    logic [3:0] req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'd1,  8'd0,  7'b0000000, 4'd4},
    '{1'b1, 8'd1,  8'd3,  7'b0000000, 4'd3},
    '{1'b1, 8'd1,  8'd4,  7'b1000000, 4'd3},
    '{1'b1, 8'd3,  8'd12, 7'b1110110, 4'd7},
    '{1'b1, 8'd3,  8'd10, 7'b1110100, 4'd7},
    '{1'b1, 8'd3,  8'd33, 7'b1110111, 4'd7},
    '{1'b1, 8'd3,  8'd34, 7'b1100000, 4'd6},
    '{1'b1, 8'd6,  8'd19, 7'b1100000, 4'd5},
    '{1'b1, 8'd6,  8'd20, 7'b1001000, 4'd5},
    '{1'b1, 8'd8,  8'd19, 7'b1011101, 4'd5},
    '{1'b1, 8'd8,  8'd20, 7'b1111110, 4'd5},
    '{1'b1, 8'd11, 8'd39, 7'b1101000, 4'd2},
    '{1'b1, 8'd1,  8'd20, 7'b1000000, 4'd2},
    '{1'b0, 8'd2,  8'd5,  7'b1000000, 4'd9},
    '{1'b0, 8'd1,  8'd5,  7'b0000000, 4'd9},
    '{1'b0, 8'd1,  8'd6,  7'b1000000, 4'd3},
    '{1'b0, 8'd3,  8'd8,  7'b1110100, 4'd7},
    '{1'b0, 8'd3,  8'd31, 7'b1110111, 4'd7},
    '{1'b0, 8'd3,  8'd32, 7'b1100000, 4'd6},
    '{1'b0, 8'd5,  8'd17, 7'b1100000, 4'd5},
    '{1'b0, 8'd5,  8'd18, 7'b1001000, 4'd5},
    '{1'b0, 8'd7,  8'd17, 7'b1011101, 4'd5},
    '{1'b0, 8'd7,  8'd18, 7'b1111110, 4'd5},
    '{1'b0, 8'd9,  8'd35, 7'b1101000, 4'd2},
    '{1'b1, 8'd1,  8'd38, 7'b1000000, 4'd9}
  };

  function automatic string tag(input logic [3:0] r);
    case (r)
      4'd1: tag = "R1";
      4'd2: tag = "R2";
      4'd3: tag = "R3";
      4'd4: tag = "R4";
      4'd5: tag = "R5";
      4'd6: tag = "R6";
      4'd7: tag = "R7";
      4'd8: tag = "R8";
      default: tag = "R9";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int expv, input string what);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic wait_pos(input int l, input int p);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(bline == l && bpx == p) && n < 5000);
  endtask

  function automatic logic [6:0] outs();
    return {hsync_n, vsync_n, blank_n, field_even, act_valid, act_phase};
  endfunction

  initial begin
    int cnt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      pal_sel = VEC[i].sel;
      wait_pos(int'(VEC[i].line), int'(VEC[i].px));
      check(tag(VEC[i].req), int'(outs()), int'(VEC[i].exp),
            $sformatf("vector %0d line %0d px %0d", i, VEC[i].line, VEC[i].px));
    end

    // R8: reset state, loading the 525-line standard (R9)
    pal_sel = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R8", int'(outs()), 0, "outputs in reset");
    check("R8", int'(pix_tick), 0, "tick in reset");
    rst = 1'b0;

    // R1: tick pattern after release
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R1", int'(pix_tick), (k % 2 == 0) ? 1 : 0, $sformatf("tick sample %0d", k));
    end

    // R3 and R2: sync width and line period in clocks for the 525-line standard
    cnt = 0;
    while (hsync_n == 1'b0 && cnt < 1000) begin @(negedge clk); cnt++; end
    cnt = 0;
    while (hsync_n == 1'b1 && cnt < 1000) begin @(negedge clk); cnt++; end
    cnt = 0;
    do begin cnt++; @(negedge clk); end while (hsync_n == 1'b0 && cnt < 1000);
    check("R3", cnt, 2 * N_HS, "hsync low clocks");
    do begin cnt++; @(negedge clk); end while (hsync_n == 1'b1 && cnt < 1000);
    check("R2", cnt, 2 * N_LINE, "line period clocks");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule